// File: doc/BRIEF.md
# Debug Communications Mailbox

This block is a single-word mailbox that carries 32-bit words in both directions between an external debugger and a processor core. The debugger reaches it through a small register port. An access is a request held until the block raises `dbg_ready`, and the block can also answer with an error flag. The core sees a receive word that it consumes with a read strobe, and a transmit word that it fills with a write strobe. Each direction holds at most one word.

Two level outputs go to an interrupt controller. `irq_rx` means a word is waiting for the core. `irq_tx` means the core may write a new word. The debugger reads both full flags in a status word.

Each channel is a two-state machine. The receive machine has the states RX_EMPTY and RX_FULL:
- It moves RX_EMPTY to RX_FULL on a debugger load.
- It moves RX_FULL to RX_EMPTY on a core read with no load in the same cycle.
- It stays in RX_FULL when a core read and a load coincide.

The transmit machine has the states TX_EMPTY and TX_FULL:
- It moves TX_EMPTY to TX_FULL on a core write.
- It moves TX_FULL to TX_EMPTY on a debugger drain.

The debugger port decodes three register selects: 0 status, 1 receive data, 2 transmit data. It drives the stall and error answers from the channel states in the same cycle.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset `irq_rx` is 0, `irq_tx` is 1, and a status read returns 0.
- R2: A debugger write to select 1 while the receive channel is empty completes in the same cycle with `dbg_ready`=1 and `dbg_err`=0. From the next cycle, `irq_rx` is 1 and `core_rx_data` holds the written word.
- R3: A `core_rx_rd` pulse while the receive channel is full drops `irq_rx` in the next cycle. A pulse while it is empty changes nothing.
- R4: A debugger write to select 1 while the receive channel is full and `core_rx_rd` is low is stalled (`dbg_ready`=0), and the held word stays unchanged. The write completes in the cycle the core reads.
- R5: When a core read and an accepted debugger write to select 1 fall in the same cycle, `irq_rx` stays 1 and `core_rx_data` becomes the new word.
- R6: A `core_tx_wr` pulse while the transmit channel is empty drops `irq_tx` in the next cycle.
- R7: A `core_tx_wr` while the transmit channel is full is ignored. The earlier word is the one the debugger later reads.
- R8: A debugger read of select 2 while the transmit channel is full completes with `dbg_err`=0 and the held word on `dbg_rdata`. `irq_tx` returns to 1 in the next cycle.
- R9: A debugger read of select 2 while the transmit channel is empty completes at once with `dbg_err`=1 and `dbg_rdata`=0.
- R10: A read of select 0 returns the receive-full flag at bit 30 and the transmit-full flag at bit 29, with all other bits 0. `irq_rx` equals bit 30 and `irq_tx` equals the inverse of bit 29.
- R11: Any other access completes at once with `dbg_err`=1 and changes no state. This covers a write to select 0 or 2, a read of select 1, and either access to select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Debugger access request, held until `dbg_ready` |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_sel | input | 2 | Register select: 0 status, 1 receive data, 2 transmit data |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data, valid when the access completes |
| dbg_ready | output | 1 | Access completes this cycle; low means stall |
| dbg_err | output | 1 | Error response for the completing access |
| core_rx_rd | input | 1 | Core consumes the receive word |
| core_rx_data | output | 32 | Receive word seen by the core |
| core_tx_wr | input | 1 | Core writes the transmit word |
| core_tx_wdata | input | 32 | Transmit word from the core |
| irq_rx | output | 1 | Level interrupt: word waiting for the core |
| irq_tx | output | 1 | Level interrupt: core may write |

## Verification
A channel machine stuck in the wrong state shows at the interrupt pins one cycle after the event that should have moved it. The same state also shows in the status word on the very next debugger read. A bad receive state appears as a stall on a write that should complete, or as a write accepted over an unread word. A bad transmit state appears as an error on a read of a full channel, or as data returned from an empty one. A corrupted data register shows at `core_rx_data`, or on `dbg_rdata` when the debugger drains the channel.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_RXDATA = 2'd1,
        SEL_TXDATA = 2'd2,
        SEL_SPARE  = 2'd3
    } dcc_sel_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_EMPTY = 1'b0,
        TX_FULL  = 1'b1
    } tx_state_e;

    localparam int RXFULL_POS = 30;
    localparam int TXFULL_POS = 29;

endpackage

// File: rtl/dcc_rx_chan.sv
module dcc_rx_chan
    import dcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          take,
    output logic          full,
    output logic          can_load,
    output logic [DW-1:0] data
);

    rx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (load)          state_d = RX_FULL;
            RX_FULL:  if (take && !load) state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (load) data <= load_data;
    end

    always_comb begin
        full     = (state_q == RX_FULL);
        can_load = (state_q == RX_EMPTY) || take;
    end

    // R3: a core read with no concurrent load empties the channel
    a_r3_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (full && take && !load) |=> !full);

    // R4: an unconsumed word is never overwritten
    a_r4_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> $stable(data));

endmodule

// File: rtl/dcc_tx_chan.sv
module dcc_tx_chan
    import dcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          drain,
    output logic          full,
    output logic [DW-1:0] data
);

    tx_state_e state_q, state_d;
    logic      accept;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY: if (push)  state_d = TX_FULL;
            TX_FULL:  if (drain) state_d = TX_EMPTY;
        endcase
    end

    always_comb begin
        full   = (state_q == TX_FULL);
        accept = (state_q == TX_EMPTY) && push;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      data <= '0;
        else if (accept) data <= push_data;
    end

    // R7: a core write into a full channel leaves the word untouched
    a_r7_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> $stable(data));

    // R6: a core write into an empty channel fills it
    a_r6_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && push) |=> full);

endmodule

// File: rtl/dcc_dbg_port.sv
module dcc_dbg_port
    import dcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          req,
    input  logic          write,
    input  logic [1:0]    sel,
    input  logic          rx_full,
    input  logic          rx_can_load,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_data,
    output logic          ready,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic          rx_load,
    output logic          tx_drain
);

    logic [DW-1:0] status_word;

    always_comb begin
        status_word             = '0;
        status_word[RXFULL_POS] = rx_full;
        status_word[TXFULL_POS] = tx_full;
    end

    always_comb begin
        ready    = 1'b1;
        err      = 1'b0;
        rdata    = '0;
        rx_load  = 1'b0;
        tx_drain = 1'b0;
        unique case (dcc_sel_e'(sel))
            SEL_STATUS: begin
                if (write) err   = req;
                else       rdata = status_word;
            end
            SEL_RXDATA: begin
                if (write) begin
                    ready   = rx_can_load;
                    rx_load = req && rx_can_load;
                end else begin
                    err = req;
                end
            end
            SEL_TXDATA: begin
                if (!write && tx_full) begin
                    rdata    = tx_data;
                    tx_drain = req;
                end else begin
                    err = req;
                end
            end
            SEL_SPARE: err = req;
        endcase
    end

endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
    import dcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_req,
    input  logic          dbg_write,
    input  logic [1:0]    dbg_sel,
    input  logic [DW-1:0] dbg_wdata,
    output logic [DW-1:0] dbg_rdata,
    output logic          dbg_ready,
    output logic          dbg_err,
    input  logic          core_rx_rd,
    output logic [DW-1:0] core_rx_data,
    input  logic          core_tx_wr,
    input  logic [DW-1:0] core_tx_wdata,
    output logic          irq_rx,
    output logic          irq_tx
);

    logic          rx_full, rx_can_load, rx_load;
    logic          tx_full, tx_drain;
    logic [DW-1:0] tx_word;

    dcc_rx_chan #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rx_load),
        .load_data (dbg_wdata),
        .take      (core_rx_rd),
        .full      (rx_full),
        .can_load  (rx_can_load),
        .data      (core_rx_data)
    );

    dcc_tx_chan #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (core_tx_wr),
        .push_data (core_tx_wdata),
        .drain     (tx_drain),
        .full      (tx_full),
        .data      (tx_word)
    );

    dcc_dbg_port #(.DW(DW)) u_port (
        .req         (dbg_req),
        .write       (dbg_write),
        .sel         (dbg_sel),
        .rx_full     (rx_full),
        .rx_can_load (rx_can_load),
        .tx_full     (tx_full),
        .tx_data     (tx_word),
        .ready       (dbg_ready),
        .err         (dbg_err),
        .rdata       (dbg_rdata),
        .rx_load     (rx_load),
        .tx_drain    (tx_drain)
    );

    assign irq_rx = rx_full;
    assign irq_tx = !tx_full;

    // R2: an accepted receive write is visible to the core next cycle
    a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && dbg_write && dbg_sel == 2'd1 && dbg_ready)
        |=> (irq_rx && core_rx_data == $past(dbg_wdata)));

    // R4: a receive write into a full channel stalls unless the core reads
    a_r4_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && dbg_write && dbg_sel == 2'd1 && irq_rx && !core_rx_rd)
        |-> !dbg_ready);

    // R8: draining a full transmit channel frees it for the core
    a_r8_drain_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !dbg_write && dbg_sel == 2'd2 && !irq_tx)
        |=> irq_tx);

    // R9: reading an empty transmit channel answers with an error at once
    a_r9_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !dbg_write && dbg_sel == 2'd2 && irq_tx)
        |-> (dbg_ready && dbg_err && dbg_rdata == '0));

    // R11: a select-3 access never moves either channel
    a_r11_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && dbg_sel == 2'd3 && !core_rx_rd && !core_tx_wr)
        |=> ($stable(irq_rx) && $stable(irq_tx)));

endmodule

// File: tb/dcc_mailbox_tb.sv
module dcc_mailbox_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    typedef struct {
        logic          is_wr;
        logic [DW-1:0] exp_data;
        logic          exp_err;
        string         tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbg_req = 1'b0;
    logic          dbg_write = 1'b0;
    logic [1:0]    dbg_sel = '0;
    logic [DW-1:0] dbg_wdata = '0;
    logic [DW-1:0] dbg_rdata;
    logic          dbg_ready;
    logic          dbg_err;
    logic          core_rx_rd = 1'b0;
    logic [DW-1:0] core_rx_data;
    logic          core_tx_wr = 1'b0;
    logic [DW-1:0] core_tx_wdata = '0;
    logic          irq_rx;
    logic          irq_tx;

    int n_cmp = 0;
    int n_bad = 0;
    exp_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dcc_mailbox #(.DW(DW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dbg_req       (dbg_req),
        .dbg_write     (dbg_write),
        .dbg_sel       (dbg_sel),
        .dbg_wdata     (dbg_wdata),
        .dbg_rdata     (dbg_rdata),
        .dbg_ready     (dbg_ready),
        .dbg_err       (dbg_err),
        .core_rx_rd    (core_rx_rd),
        .core_rx_data  (core_rx_data),
        .core_tx_wr    (core_tx_wr),
        .core_tx_wdata (core_tx_wdata),
        .irq_rx        (irq_rx),
        .irq_tx        (irq_tx)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each completing debugger access against the queue
    always @(negedge clk) begin
        if (rst_n && dbg_req && dbg_ready) begin
            if (exp_q.size() == 0) begin
                check("unexpected completion", 32'd1, 32'd0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check({it.tag, " err"}, {31'd0, dbg_err}, {31'd0, it.exp_err});
                if (!it.is_wr) check({it.tag, " rdata"}, dbg_rdata, it.exp_data);
            end
        end
    end

    task automatic dbg_access(input logic wr, input logic [1:0] sel, input logic [DW-1:0] wd,
                              input logic [DW-1:0] exp_d, input logic exp_e, input string tag);
        exp_item_t it;
        it.is_wr = wr; it.exp_data = exp_d; it.exp_err = exp_e; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk); #1;
        dbg_req = 1'b1; dbg_write = wr; dbg_sel = sel; dbg_wdata = wd;
        forever begin
            @(negedge clk);
            if (dbg_ready) break;
        end
        @(posedge clk); #1;
        dbg_req = 1'b0; dbg_write = 1'b0;
    endtask

    task automatic core_read;
        @(posedge clk); #1; core_rx_rd = 1'b1;
        @(posedge clk); #1; core_rx_rd = 1'b0;
    endtask

    task automatic core_write(input logic [DW-1:0] w);
        @(posedge clk); #1; core_tx_wr = 1'b1; core_tx_wdata = w;
        @(posedge clk); #1; core_tx_wr = 1'b0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq_rx", {31'd0, irq_rx}, 32'd0);
        check("R1 irq_tx", {31'd0, irq_tx}, 32'd1);
        dbg_access(1'b0, 2'd0, '0, 32'h0, 1'b0, "R1 status");

        dbg_access(1'b0, 2'd2, '0, 32'h0, 1'b1, "R9 empty tx read");
        dbg_access(1'b0, 2'd1, '0, 32'h0, 1'b1, "R11 rx read");
        dbg_access(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0, 1'b1, "R11 status write");
        dbg_access(1'b1, 2'd2, 32'h1234_5678, 32'h0, 1'b1, "R11 tx write");
        dbg_access(1'b1, 2'd3, 32'h1234_5678, 32'h0, 1'b1, "R11 spare write");
        @(negedge clk);
        check("R11 irq_rx unchanged", {31'd0, irq_rx}, 32'd0);
        check("R11 irq_tx unchanged", {31'd0, irq_tx}, 32'd1);

        dbg_access(1'b1, 2'd1, 32'hA5A5_0001, 32'h0, 1'b0, "R2 rx write");
        @(negedge clk);
        check("R2 irq_rx", {31'd0, irq_rx}, 32'd1);
        check("R2 core_rx_data", core_rx_data, 32'hA5A5_0001);
        dbg_access(1'b0, 2'd0, '0, 32'h4000_0000, 1'b0, "R10 status rx full");

        fork
            dbg_access(1'b1, 2'd1, 32'hB0B0_0002, 32'h0, 1'b0, "R4 stalled write");
            begin
                @(posedge clk); #1;
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    check("R4 ready low", {31'd0, dbg_ready}, 32'd0);
                    check("R4 word held", core_rx_data, 32'hA5A5_0001);
                end
                core_read();
            end
        join
        @(negedge clk);
        check("R5 irq_rx stays", {31'd0, irq_rx}, 32'd1);
        check("R5 new word", core_rx_data, 32'hB0B0_0002);

        core_read();
        @(negedge clk);
        check("R3 irq_rx drop", {31'd0, irq_rx}, 32'd0);
        core_read();
        @(negedge clk);
        check("R3 read when empty", {31'd0, irq_rx}, 32'd0);
        dbg_access(1'b0, 2'd0, '0, 32'h0, 1'b0, "R3 status empty");

        core_write(32'hC0DE_0003);
        @(negedge clk);
        check("R6 irq_tx drop", {31'd0, irq_tx}, 32'd0);
        dbg_access(1'b0, 2'd0, '0, 32'h2000_0000, 1'b0, "R10 status tx full");
        core_write(32'hDEAD_0004);
        @(negedge clk);
        check("R7 irq_tx still low", {31'd0, irq_tx}, 32'd0);
        dbg_access(1'b0, 2'd2, '0, 32'hC0DE_0003, 1'b0, "R7 R8 tx read");
        @(negedge clk);
        check("R8 irq_tx back", {31'd0, irq_tx}, 32'd1);
        dbg_access(1'b0, 2'd2, '0, 32'h0, 1'b1, "R9 drained tx read");

        dbg_access(1'b1, 2'd1, 32'hE000_0005, 32'h0, 1'b0, "R2 second write");
        fork
            dbg_access(1'b1, 2'd1, 32'hF000_0006, 32'h0, 1'b0, "R5 concurrent write");
            core_read();
        join
        @(negedge clk);
        check("R5 concurrent irq_rx", {31'd0, irq_rx}, 32'd1);
        check("R5 concurrent word", core_rx_data, 32'hF000_0006);
        dbg_access(1'b0, 2'd0, '0, 32'h4000_0000, 1'b0, "R10 final status");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) check("queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule